// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit offset into a 20-bit physical address in the real-mode style. It keeps four 16-bit segment registers: extra, code, stack and data. For every request it picks one of them, multiplies the value by sixteen (a left shift by four bits) and adds the offset. Any carry out of the top bit is dropped.

The segment register is chosen by the kind of access. Instruction fetches use the code segment, ordinary data accesses use the data segment, stack pushes and pops use the stack segment, and string-destination accesses use the extra segment. A caller may ask for a different segment with an override flag and a 2-bit register code. The override is honoured for data and string-destination accesses. It is ignored for fetches and for stack accesses.

Segment registers are loaded through a single write port. The address and its valid flag are registered, so each result appears one clock after its request.

Top module: `seg_addr_gen`

## Requirements
- R1: The address equals the selected 16-bit segment shifted left by 4 plus the zero-extended 16-bit offset. Segment 1234h with offset 5678h gives 179B8h, and segment 1005h with offset 5555h gives 155A5h.
- R2: With no override, the access kind selects the segment: kind 00 (fetch) uses code, 01 (data) uses data, 10 (stack) uses stack, and 11 (string destination) uses extra.
- R3: For kinds 01 and 11, an asserted override replaces the default with the segment named by the override code. The codes are 00 extra, 01 code, 10 stack and 11 data.
- R4: For kind 00 (fetch), the override flag and code have no effect and the code segment is always used.
- R5: For kind 10 (stack), the override flag and code have no effect and the stack segment is always used.
- R6: A carry out of bit 19 is discarded, so the address wraps modulo 2^20. For example, segment FFFFh with offset FFFFh gives 0FFEFh.
- R7: The valid output is high in exactly the cycle after a request. When there is no request, the address output holds its previous value.
- R8: The write port uses the same 2-bit code as the override. A value written in a cycle is first used by requests in the following cycle, and a request in the same cycle still sees the old value.
- R9: Reset clears all four segment registers, the address output and the valid output to zero.
- R10: When the offset is zero, the lowest four bits of the address are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Segment register write enable |
| wr_sel | input | 2 | Segment register to write (00 extra, 01 code, 10 stack, 11 data) |
| wr_data | input | 16 | Value to write |
| req_valid | input | 1 | Address request |
| req_kind | input | 2 | Access kind (00 fetch, 01 data, 10 stack, 11 string destination) |
| ovr_valid | input | 1 | Segment override requested |
| ovr_code | input | 2 | Overriding segment register (same encoding as wr_sel) |
| offset | input | 16 | Effective address |
| addr_out | output | 20 | Registered physical address |
| addr_valid | output | 1 | Address output valid |

## Verification
A wrong segment register value, or a wrong selection, shows up as a wrong address on the very next valid output. The difference is always a multiple of sixteen and leaves the low nibble untouched. A write that lands on the wrong register stays hidden until a request of the affected kind arrives, so the bench cycles through every kind and override after each write. A valid flag or a held address that drifts out of step is visible one clock after the request or idle cycle that caused it.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  typedef enum logic [1:0] {
    SEG_ES = 2'b00,
    SEG_CS = 2'b01,
    SEG_SS = 2'b10,
    SEG_DS = 2'b11
  } seg_code_e;

  typedef enum logic [1:0] {
    ACC_FETCH  = 2'b00,
    ACC_DATA   = 2'b01,
    ACC_STACK  = 2'b10,
    ACC_STRDST = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int SEG_W = 16,
  parameter int NSEG  = 4,
  localparam int SEL_W = $clog2(NSEG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_sel,
  input  logic [SEG_W-1:0]           wr_data,
  output logic [NSEG-1:0][SEG_W-1:0] seg_q
);
  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    logic             load;
    logic [SEG_W-1:0] seg_d;

    always_comb begin
      load  = wr_en && (wr_sel == SEL_W'(i));
      seg_d = load ? wr_data : seg_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seg_q[i] <= '0;
      else        seg_q[i] <= seg_d;
    end
  end
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int NSEG  = 4
) (
  input  logic [1:0]                 req_kind,
  input  logic                       ovr_valid,
  input  logic [1:0]                 ovr_code,
  input  logic [NSEG-1:0][SEG_W-1:0] seg_q,
  output logic [SEG_W-1:0]           seg_val
);
  seg_code_e pick;

  always_comb begin
    unique case (acc_kind_e'(req_kind))
      ACC_FETCH:  pick = SEG_CS;
      ACC_STACK:  pick = SEG_SS;
      ACC_DATA:   pick = ovr_valid ? seg_code_e'(ovr_code) : SEG_DS;
      ACC_STRDST: pick = ovr_valid ? seg_code_e'(ovr_code) : SEG_ES;
      default:    pick = SEG_DS;
    endcase
    seg_val = seg_q[pick];
  end
endmodule

// File: rtl/seg_addr_adder.sv
module seg_addr_adder #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg_val,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off_ext;

  always_comb begin
    base    = {seg_val, {SHIFT{1'b0}}};
    off_ext = ADDR_W'(offset);
    addr    = base + off_ext;
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int NSEG  = 4,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [SEG_W-1:0]  wr_data,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              ovr_valid,
  input  logic [1:0]        ovr_code,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_valid
);
  logic                       rst_meta_n;
  logic                       rst_sync_n;
  logic [NSEG-1:0][SEG_W-1:0] seg_q;
  logic [SEG_W-1:0]           seg_val;
  logic [ADDR_W-1:0]          addr_sum;
  logic [ADDR_W-1:0]          addr_d;
  logic                       valid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  seg_regfile #(.SEG_W(SEG_W), .NSEG(NSEG)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .seg_q(seg_q)
  );

  seg_select #(.SEG_W(SEG_W), .NSEG(NSEG)) u_sel (
    .req_kind(req_kind), .ovr_valid(ovr_valid), .ovr_code(ovr_code),
    .seg_q(seg_q), .seg_val(seg_val)
  );

  seg_addr_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_add (
    .seg_val(seg_val), .offset(offset), .addr(addr_sum)
  );

  always_comb begin
    valid_d = req_valid;
    addr_d  = req_valid ? addr_sum : addr_out;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_out   <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_out   <= addr_d;
      addr_valid <= valid_d;
    end
  end
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic [OFF_W-1:0]  offset,
  input logic [SEG_W-1:0]  seg_cs,
  input logic [SEG_W-1:0]  seg_ss,
  input logic [ADDR_W-1:0] addr_out,
  input logic              addr_valid
);
  p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_valid);

  p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!addr_valid && $stable(addr_out)));

  p_fetch_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'b00) |=>
      addr_out == ({$past(seg_cs), {SHIFT{1'b0}}} + ADDR_W'($past(offset))));

  p_stack_seg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'b10) |=>
      addr_out == ({$past(seg_ss), {SHIFT{1'b0}}} + ADDR_W'($past(offset))));

  p_low_nibble_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && offset == '0) |=> addr_out[SHIFT-1:0] == '0);
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_kind(req_kind),
  .offset(offset), .seg_cs(seg_q[1]), .seg_ss(seg_q[2]),
  .addr_out(addr_out), .addr_valid(addr_valid)
);

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic        ovr_valid = 1'b0;
  logic [1:0]  ovr_code = '0;
  logic [15:0] offset = '0;
  logic [19:0] addr_out;
  logic        addr_valid;

  int checks = 0;
  int fails  = 0;
  bit live   = 0;
  bit done   = 0;

  int m_seg [4];
  int m_addr = 0;
  bit m_valid = 0;

  always #10 clk = ~clk;

  seg_addr_gen u_seg_addr_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req_valid(req_valid), .req_kind(req_kind), .ovr_valid(ovr_valid),
    .ovr_code(ovr_code), .offset(offset), .addr_out(addr_out), .addr_valid(addr_valid)
  );

  function automatic int pick_seg(int kind, bit ov, int code);
    if (kind == 0) return 1;
    if (kind == 2) return 2;
    if (ov) return code;
    return (kind == 1) ? 3 : 0;
  endfunction

  // reference model, one step per clock
  always @(posedge clk) begin
    if (live) begin
      m_valid = req_valid;
      if (req_valid)
        m_addr = (m_seg[pick_seg(int'(req_kind), ovr_valid, int'(ovr_code))] * 16
                  + int'(offset)) % 1048576;
      if (wr_en) m_seg[wr_sel] = int'(wr_data);
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %05h expected %05h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && !done) begin
      check("R7 valid", int'(addr_valid), int'(m_valid));
      check("R2 model address", int'(addr_out), m_addr);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  task automatic wr(int sel, int data);
    @(negedge clk);
    wr_en = 1; wr_sel = 2'(sel); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rq(int kind, bit ov, int code, int off);
    @(negedge clk);
    req_valid = 1; req_kind = 2'(kind); ovr_valid = ov;
    ovr_code = 2'(code); offset = 16'(off);
    @(negedge clk);
    req_valid = 0; ovr_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_seg[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R9 valid after reset", int'(addr_valid), 0);
    check("R9 addr after reset", int'(addr_out), 0);
    live = 1;
    rq(1, 0, 0, 'h0010);
    check("R9 segments cleared", int'(addr_out), 'h00010);

    wr(1, 'h1234);
    rq(0, 0, 0, 'h5678);
    check("R1 code 1234:5678", int'(addr_out), 'h179B8);
    wr(3, 'h1005);
    rq(1, 0, 0, 'h5555);
    check("R1 data 1005:5555", int'(addr_out), 'h155A5);
    @(negedge clk);
    check("R7 hold valid", int'(addr_valid), 0);
    check("R7 hold addr", int'(addr_out), 'h155A5);

    wr(0, 'h2000);
    rq(3, 0, 0, 'h0001);
    check("R2 string default extra", int'(addr_out), 'h20001);
    rq(1, 1, 0, 'h0100);
    check("R3 data override extra", int'(addr_out), 'h20100);
    rq(3, 1, 1, 'h0008);
    check("R3 string override code", int'(addr_out), 'h12348);
    rq(0, 1, 3, 'h5678);
    check("R4 fetch ignores override", int'(addr_out), 'h179B8);

    wr(2, 'h3000);
    rq(2, 1, 0, 'h00FE);
    check("R5 stack ignores override", int'(addr_out), 'h300FE);

    // write and request in the same cycle
    @(negedge clk);
    wr_en = 1; wr_sel = 2'd2; wr_data = 16'hFFFF;
    req_valid = 1; req_kind = 2'd2; offset = 16'h0002;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    check("R8 same-cycle write unseen", int'(addr_out), 'h30002);
    rq(2, 0, 0, 'hFFFF);
    check("R6 wrap FFFF:FFFF", int'(addr_out), 'h0FFEF);
    rq(1, 1, 2, 'h0000);
    check("R10 zero offset low nibble", int'(addr_out) & 'hF, 0);
    check("R3 data override stack", int'(addr_out), 'hFFFF0);

    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      wr_en = ($urandom % 4) == 0;
      wr_sel = 2'($urandom); wr_data = 16'($urandom);
      req_valid = ($urandom % 3) != 0;
      req_kind = 2'($urandom); ovr_valid = 1'($urandom);
      ovr_code = 2'($urandom); offset = 16'($urandom);
    end
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule